// File: doc/BRIEF.md
# I2C Byte-Memory Read Target

This block is an I2C target that sits in front of a byte-wide memory and answers reads. It watches the SCL and SDA lines, which arrive already synchronized to the system clock. It drives SDA only through an open-drain pull-down enable. It recognizes START, repeated START and STOP. It compares the first byte of each transfer against a 7-bit target address. It fetches data from a memory array through a one-cycle synchronous read port.

A byte pointer survives from one transaction to the next. A plain read begins wherever the previous access left off. A write carrying a single byte address moves the pointer without storing anything. If that write is followed by a repeated START and a read, the result is a random-address read. While the master acknowledges each byte, the target keeps sending the following bytes. The pointer wraps from the last location back to zero.

The memory depth and the target address are parameters. The default is a 256-byte array with an 8-bit pointer.

Top module: `i2c_rdmem_target`

## Requirements
- R1: When the 8 bits after a START hold the target address with a read flag (bit value 1 in the final position), the target pulls SDA low while SCL is high in the 9th clock. It then sends the byte at the pointer, most significant bit first.
- R2: The target starts pulling SDA low only while SCL is low. It leaves SDA released during the 9th clock of every byte it sends.
- R3: Every byte the target sends advances the pointer by one, whether the master acknowledges it or not. A new read with no address phase starts at the pointer.
- R4: Stepping past location MEM_DEPTH-1 moves the pointer to 0. This holds inside a burst and between transactions.
- R5: A master acknowledge (SDA low in the 9th clock) makes the target send the next byte. There is no limit on how many bytes a burst may contain.
- R6: A master no-acknowledge (SDA high in the 9th clock) ends the transfer. The target then pulls SDA low on no later clock until a START arrives.
- R7: A matching address with a write flag (bit value 0) is acknowledged. So is the byte-address byte that follows it. That byte loads the pointer, and no memory write takes place. Any later bytes of the same write are not acknowledged.
- R8: A repeated START after the byte address, followed by a matching read address, sends data starting at the newly loaded address.
- R9: An address byte that does not match is not acknowledged. After it, the target ignores every bus bit until the next START or STOP, including bytes that would match.
- R10: A START or STOP in the middle of a byte abandons the transfer, releases SDA, and leaves the pointer unchanged.
- R11: The target fetches each data byte by holding mem_rd_en high for one clock with mem_addr equal to the pointer. It takes mem_rdata one clock later.
- R12: After reset, SDA is released and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| mem_rd_en | output | 1 | One-cycle read strobe to memory |
| mem_addr | output | ADDR_W | Read address (the pointer) |
| mem_rdata | input | 8 | Read data, valid one cycle after the strobe |

## Verification
The bench builds the target with its default parameters: MEM_DEPTH of 256 and target address 0x50. With a power-of-two depth, the plain-increment wrap variant is the one elaborated. With 256 locations, the roll-over from 0xFF to 0x00 can be reached with a short burst after a random read to 0xFE. It can also be reached across transaction boundaries after a single read at 0xFF. The target address 0x50 is one bit away from the mismatch byte the bench sends, 0x51. The bench also sends a matching byte while the target ignores the bus, which shows that matching is gated by the START.

// File: rtl/i2c_rdm_pkg.sv
package i2c_rdm_pkg;

   localparam int BYTE_BITS = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK_R,
      ST_DEV_ACK_W,
      ST_WADDR,
      ST_WADDR_ACK,
      ST_TX,
      ST_TX_MACK,
      ST_TX_LOAD,
      ST_IGNORE
   } rdm_state_e;

endpackage

// File: rtl/i2c_rdm_cond.sv
// Bus edge and condition detector on already-synchronized lines.
module i2c_rdm_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise  = !scl_q && scl_i;
   assign scl_fall  = scl_q && !scl_i;
   // SDA moving while SCL stays high marks a bus condition
   assign start_det = scl_q && scl_i && sda_q && !sda_i;
   assign stop_det  = scl_q && scl_i && !sda_q && sda_i;

endmodule

// File: rtl/i2c_rdm_ptr.sv
// Persistent byte pointer; the wrap logic is chosen by depth.
module i2c_rdm_ptr #(
   parameter  int MEM_DEPTH = 256,
   localparam int ADDR_W    = $clog2(MEM_DEPTH),
   localparam bit IS_POW2   = ((1 << ADDR_W) == MEM_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [7:0]        load_byte,
   input  logic              inc,
   output logic [ADDR_W-1:0] ptr
);

   logic [ADDR_W-1:0] nxt_inc;
   logic [ADDR_W-1:0] ld_val;

   generate
      if (IS_POW2) begin : g_pow2
         assign nxt_inc = ptr + 1'b1;
         assign ld_val  = load_byte[ADDR_W-1:0];
      end else begin : g_cmp
         localparam logic [ADDR_W-1:0] TOP = ADDR_W'(MEM_DEPTH - 1);
         assign nxt_inc = (ptr == TOP) ? '0 : ptr + 1'b1;
         assign ld_val  = (load_byte >= 8'(MEM_DEPTH)) ? '0 : load_byte[ADDR_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (load) ptr <= ld_val;
      else if (inc)  ptr <= nxt_inc;
   end

endmodule

// File: rtl/i2c_rdm_ctrl.sv
// Byte-level protocol sequencer: address match, ack, shift-out, fetch.
module i2c_rdm_ctrl
   import i2c_rdm_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h50
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sda_i,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic [7:0] mem_rdata,
   output logic       sda_oe,
   output logic       mem_rd_en,
   output logic       ptr_load,
   output logic [7:0] ptr_byte,
   output logic       ptr_inc,
   output logic       ignore_st
);

   localparam logic [3:0] LAST_BIT = 4'(BYTE_BITS);

   rdm_state_e state;
   logic [3:0] cnt;
   logic [7:0] sh;
   logic [7:0] tx;
   logic       rd_q;
   logic       cap_q;

   assign mem_rd_en = rd_q;
   assign ptr_byte  = sh;
   assign ptr_load  = (state == ST_WADDR) && scl_fall && (cnt == LAST_BIT);
   assign ptr_inc   = (state == ST_TX_MACK) && scl_rise;
   assign ignore_st = (state == ST_IGNORE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         sh     <= '0;
         tx     <= '0;
         sda_oe <= 1'b0;
         rd_q   <= 1'b0;
         cap_q  <= 1'b0;
      end else begin
         rd_q  <= 1'b0;
         cap_q <= rd_q;
         if (cap_q) tx <= mem_rdata;
         if (start_det) begin
            state  <= ST_DEV;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_DEV: begin
                  if (scl_rise) begin
                     sh  <= {sh[6:0], sda_i};
                     cnt <= cnt + 4'd1;
                  end else if (scl_fall && cnt == LAST_BIT) begin
                     cnt <= '0;
                     if (sh[7:1] == DEV_ADDR) begin
                        sda_oe <= 1'b1;
                        if (sh[0]) begin
                           state <= ST_DEV_ACK_R;
                           rd_q  <= 1'b1;
                        end else begin
                           state <= ST_DEV_ACK_W;
                        end
                     end else begin
                        state <= ST_IGNORE;
                     end
                  end
               end
               ST_DEV_ACK_W: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     state  <= ST_WADDR;
                  end
               end
               ST_WADDR: begin
                  if (scl_rise) begin
                     sh  <= {sh[6:0], sda_i};
                     cnt <= cnt + 4'd1;
                  end else if (scl_fall && cnt == LAST_BIT) begin
                     cnt    <= '0;
                     sda_oe <= 1'b1;
                     state  <= ST_WADDR_ACK;
                  end
               end
               ST_WADDR_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     state  <= ST_IGNORE;
                  end
               end
               ST_DEV_ACK_R, ST_TX_LOAD: begin
                  if (scl_fall) begin
                     sda_oe <= ~tx[7];
                     sh     <= {tx[6:0], 1'b0};
                     cnt    <= '0;
                     state  <= ST_TX;
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     cnt <= cnt + 4'd1;
                  end else if (scl_fall) begin
                     if (cnt == LAST_BIT) begin
                        sda_oe <= 1'b0;
                        state  <= ST_TX_MACK;
                     end else begin
                        sda_oe <= ~sh[7];
                        sh     <= {sh[6:0], 1'b0};
                     end
                  end
               end
               ST_TX_MACK: begin
                  if (scl_rise) begin
                     if (!sda_i) begin
                        rd_q  <= 1'b1;
                        state <= ST_TX_LOAD;
                     end else begin
                        state <= ST_IGNORE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/i2c_rdmem_target.sv
module i2c_rdmem_target #(
   parameter  int         MEM_DEPTH = 256,
   parameter  logic [6:0] DEV_ADDR  = 7'h50,
   localparam int         ADDR_W    = $clog2(MEM_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_rdata
);

   generate
      if (MEM_DEPTH < 2 || MEM_DEPTH > 256) begin : g_bad_depth
         $error("MEM_DEPTH must lie in 2..256 to fit a one-byte address");
      end
   endgenerate

   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic              ptr_load;
   logic              ptr_inc;
   logic [7:0]        ptr_byte;
   logic              ignore_st;
   logic [ADDR_W-1:0] ptr_q;

   i2c_rdm_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_rdm_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_i     (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .mem_rdata (mem_rdata),
      .sda_oe    (sda_oe),
      .mem_rd_en (mem_rd_en),
      .ptr_load  (ptr_load),
      .ptr_byte  (ptr_byte),
      .ptr_inc   (ptr_inc),
      .ignore_st (ignore_st)
   );

   i2c_rdm_ptr #(.MEM_DEPTH(MEM_DEPTH)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ptr_load),
      .load_byte (ptr_byte),
      .inc       (ptr_inc),
      .ptr       (ptr_q)
   );

   assign mem_addr = ptr_q;

endmodule

// File: rtl/i2c_rdm_chk.sv
module i2c_rdm_chk #(
   parameter  int MEM_DEPTH = 256,
   localparam int ADDR_W    = $clog2(MEM_DEPTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_oe,
   input logic [ADDR_W-1:0] ptr,
   input logic              ptr_load,
   input logic              start_det,
   input logic              stop_det,
   input logic              ignore_st
);

   localparam logic [ADDR_W-1:0] TOP = ADDR_W'(MEM_DEPTH - 1);

   // R2
   oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_i);

   // R10
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   // R10
   start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe);

   // R9
   ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ignore_st |-> !sda_oe);

   // R4
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ptr != $past(ptr)) && !$past(ptr_load)) |->
         (ptr == (($past(ptr) == TOP) ? '0 : ADDR_W'($past(ptr) + 1'b1))));

endmodule

bind i2c_rdmem_target i2c_rdm_chk #(.MEM_DEPTH(MEM_DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_i     (scl_i),
   .sda_oe    (sda_oe),
   .ptr       (ptr_q),
   .ptr_load  (ptr_load),
   .start_det (start_det),
   .stop_det  (stop_det),
   .ignore_st (ignore_st)
);

// File: tb/tb_i2c_rdmem_target.sv
module tb_i2c_rdmem_target;

   localparam int H = 6;
   localparam logic [7:0] A_RD = 8'hA1;
   localparam logic [7:0] A_WR = 8'hA0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       m_low = 1'b0;
   logic       sda_line;
   logic       sda_oe;
   logic       mem_rd_en;
   logic [7:0] mem_addr;
   logic [7:0] mem_rdata = 8'h00;

   int n_tests = 0;
   int n_fail  = 0;
   logic [7:0] exp_ptr = 8'h00;

   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] got_byte;
   event       byte_ev;

   always #5 clk = ~clk;

   assign sda_line = !(m_low || sda_oe);

   i2c_rdmem_target dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl),
      .sda_i     (sda_line),
      .sda_oe    (sda_oe),
      .mem_rd_en (mem_rd_en),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata)
   );

   function automatic logic [7:0] pat(input logic [7:0] a);
      logic [7:0] m;
      m = a * 8'd13;
      return m ^ 8'h5A;
   endfunction

   // R11: memory model with a one-cycle synchronous read
   always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= pat(mem_addr);

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected bytes as the master receives them
   initial begin
      forever begin
         @(byte_ev);
         if (exp_q.size() == 0) begin
            chk(1'b0, "R1 unexpected byte", got_byte, 0);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(got_byte == e, t, got_byte, e);
         end
      end
   end

   task automatic hw(); repeat (H) @(negedge clk); endtask

   task automatic bus_start();
      m_low = 1'b0; hw();
      scl = 1'b1; hw();
      m_low = 1'b1; hw();
      scl = 1'b0; hw();
   endtask

   task automatic bus_stop();
      m_low = 1'b1; hw();
      scl = 1'b1; hw();
      m_low = 1'b0; hw();
   endtask

   task automatic bit_out(input logic b);
      m_low = !b; hw();
      scl = 1'b1; hw();
      scl = 1'b0;
   endtask

   task automatic bit_in(output logic b);
      m_low = 1'b0; hw();
      scl = 1'b1;
      repeat (H/2) @(negedge clk);
      b = sda_line;
      repeat (H - H/2) @(negedge clk);
      scl = 1'b0;
   endtask

   task automatic put_byte(input logic [7:0] v, output logic acked);
      logic a;
      for (int i = 7; i >= 0; i--) bit_out(v[i]);
      bit_in(a);
      acked = !a;
   endtask

   // driver: pushes expectation, clocks in one byte, then answers
   task automatic get_byte(input bit mack, input string tag);
      logic [7:0] v;
      logic b;
      exp_q.push_back(pat(exp_ptr));
      tag_q.push_back(tag);
      exp_ptr = exp_ptr + 8'd1;
      for (int i = 7; i >= 0; i--) begin
         bit_in(b);
         v[i] = b;
      end
      got_byte = v;
      ->byte_ev;
      m_low = mack; hw();
      scl = 1'b1;
      repeat (H/2) @(negedge clk);
      if (!mack) chk(sda_line == 1'b1, "R2 released in 9th clock", sda_line, 1);
      repeat (H - H/2) @(negedge clk);
      scl = 1'b0;
   endtask

   task automatic read_burst(input int n, input string tag);
      logic ack;
      put_byte(A_RD, ack);
      chk(ack, "R1 read address ack", ack, 1);
      for (int i = 0; i < n; i++) get_byte(i != n - 1, tag);
   endtask

   task automatic random_read(input logic [7:0] a, input int n, input string tag);
      logic ack;
      bus_start();
      put_byte(A_WR, ack);
      chk(ack, "R7 write address ack", ack, 1);
      put_byte(a, ack);
      chk(ack, "R7 byte address ack", ack, 1);
      exp_ptr = a;
      bus_start();
      read_burst(n, tag);
      bus_stop();
   endtask

   task automatic cur_read(input int n, input string tag);
      bus_start();
      read_burst(n, tag);
      bus_stop();
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic ack;
      logic b;
      repeat (4) @(negedge clk);
      chk(sda_oe == 1'b0, "R12 sda released in reset", sda_oe, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(sda_oe == 1'b0, "R12 sda released after reset", sda_oe, 0);

      // R12 R1 R5 R11: pointer starts at 0, two-byte burst
      cur_read(2, "R12 R5 R11 data after reset");
      // R3: next read continues one past the last byte
      cur_read(1, "R3 current address read");
      // R8: dummy write then repeated START
      random_read(8'h10, 3, "R8 random read data");

      // R7: write-only pointer load; extra data byte refused
      bus_start();
      put_byte(A_WR, ack);
      chk(ack, "R7 write address ack", ack, 1);
      put_byte(8'h40, ack);
      chk(ack, "R7 byte address ack", ack, 1);
      put_byte(8'h99, ack);
      chk(!ack, "R7 extra data byte not acked", ack, 0);
      bus_stop();
      exp_ptr = 8'h40;
      cur_read(1, "R7 pointer loaded, no store");

      // R4: wrap inside a burst
      random_read(8'hFE, 4, "R4 R5 burst wrap");
      // R4: wrap between transactions
      random_read(8'hFF, 1, "R4 read at top");
      cur_read(1, "R4 wrap across transactions");

      // R9: mismatch then an ignored matching byte
      bus_start();
      put_byte(8'hA3, ack);
      chk(!ack, "R9 mismatch not acked", ack, 0);
      put_byte(A_RD, ack);
      chk(!ack, "R9 bus ignored after mismatch", ack, 0);
      bus_stop();
      cur_read(1, "R9 pointer untouched");

      // R10: STOP in the middle of the byte address
      bus_start();
      put_byte(A_WR, ack);
      chk(ack, "R10 write address ack", ack, 1);
      for (int i = 0; i < 4; i++) bit_out(i == 0);
      bus_stop();
      cur_read(1, "R10 pointer kept after stop abort");
      // R10: START in the middle of an address byte
      bus_start();
      bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
      bus_start();
      read_burst(1, "R10 read after start abort");
      bus_stop();

      // R5: long burst
      random_read(8'h80, 40, "R5 long burst");

      // R6: after no-acknowledge the target stays silent
      cur_read(1, "R6 byte before nack");
      bus_start();
      read_burst(1, "R6 byte then nack");
      for (int i = 0; i < 9; i++) begin
         bit_in(b);
         chk(b == 1'b1, "R6 silent after nack", b, 1);
      end
      bus_stop();
      cur_read(1, "R6 R3 pointer after nack");

      repeat (10) @(negedge clk);
      chk(exp_q.size() == 0, "R1 all expected bytes seen", exp_q.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule